// File: doc/BRIEF.md
# Tightly coupled memory access arbiter

This block sits between four requesters and two tightly coupled memories and decides, every clock, which requester owns each memory port. The requesters are a load-store path, an instruction prefetch path, a DMA slave port and a debug port. The instruction memory has one 64-bit port. The data memory is split into two independent 32-bit banks, and each bank serves one access per cycle. So up to three accesses, one per port, are granted in the same clock.

Each requester presents a request flag, an address, a write enable, byte strobes and write data. The grant is returned combinationally in the same cycle. A granted access completes at the next rising edge with no wait states. A granted read returns its data with a valid flag exactly one cycle after the grant. A requester that loses arbitration sees its grant low and keeps its request up until it wins. The prefetch path may only read. A write attempt from it is refused and reported on an error pulse. The memory arrays are outside the block: each port drives enable, write enable, word index, strobes and write data to a synchronous RAM, and takes back that RAM's registered read data.

Top module: `tcm_arbiter`

## Requirements
- R1: While reset is high every grant is low, even if all requesters are requesting. After reset, `rvalid_o` and `pf_err_o` stay low until a read has been granted or a prefetch write has been seen.
- R2: A prefetch request (requester 1) with write enable high is never granted and never reaches a memory port. In the cycle after each such request, `pf_err_o` is high; otherwise it is low.
- R3: An address with bit ADDR_W-1 equal to 0 targets the instruction memory. The 64-bit word index is address bits ADDR_W-2 down to 3. All 64 data bits and all 8 strobes are used.
- R4: An address with bit ADDR_W-1 equal to 1 targets the data memory. Address bit 2 selects the bank: 0 for bank 0 and 1 for bank 1. The word index is address bits ADDR_W-2 down to 3, and the access uses wdata bits 31:0 and strobes 3:0. Read data comes back zero-extended in rdata bits 31:0.
- R5: Two requesters that each win a different data bank are both granted in the same cycle.
- R6: On each port the order of precedence is fixed: debug (3) first, then load-store (0), then DMA (2), then prefetch (1). Every losing requester sees its grant low.
- R7: A granted read raises `rvalid_o` for that requester exactly one cycle later, carrying the memory word. A granted write takes effect at the edge that ends its grant cycle and raises no `rvalid_o`.
- R8: On a write, only the bytes whose strobe bit is 1 change. Strobe bit k covers data bits 8k+7 down to 8k.
- R9: The load-store, DMA and debug requesters can each read and write both memories, with no dependence on the other requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request flag per requester (0 load-store, 1 prefetch, 2 DMA, 3 debug) |
| addr_i | input | 4*ADDR_W | Byte address per requester, requester r at bits r*ADDR_W upward |
| we_i | input | 4 | Write enable per requester |
| be_i | input | 32 | Byte strobes, 8 per requester |
| wdata_i | input | 256 | Write data, 64 per requester |
| gnt_o | output | 4 | Grant per requester, same cycle |
| rvalid_o | output | 4 | Read data valid, one cycle after a granted read |
| rdata_o | output | 256 | Read data, 64 per requester |
| pf_err_o | output | 1 | Refused prefetch write, one cycle after the attempt |
| itcm_en_o | output | 1 | Instruction memory access enable |
| itcm_we_o | output | 1 | Instruction memory write enable |
| itcm_idx_o | output | ADDR_W-4 | Instruction memory word index |
| itcm_be_o | output | 8 | Instruction memory byte strobes |
| itcm_wdata_o | output | 64 | Instruction memory write data |
| itcm_rdata_i | input | 64 | Instruction memory registered read data |
| dtcm_en_o | output | 2 | Data bank access enables, bank b at bit b |
| dtcm_we_o | output | 2 | Data bank write enables |
| dtcm_idx_o | output | 2*(ADDR_W-4) | Data bank word indices |
| dtcm_be_o | output | 8 | Data bank byte strobes, 4 per bank |
| dtcm_wdata_o | output | 64 | Data bank write data, 32 per bank |
| dtcm_rdata_i | input | 64 | Data bank registered read data, 32 per bank |

## Verification
The assertions take for granted that the inputs change only away from the rising edge and hold a known value whenever the matching request flag is high. They also assume that each memory returns data for an enabled read at the very next edge and leaves it unchanged when not enabled. The bench drives every input just after the falling edge, and its RAM models register read data on the rising edge. Because the arbiter keeps no state between requests, the sweeps change the request pattern every cycle instead of holding a stalled request. This exercises every requester mask across every mix of targets without depending on an earlier loss.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

    localparam int NUM_REQ  = 4;
    localparam int NUM_PORT = 3;

    localparam int REQ_LS  = 0;
    localparam int REQ_PF  = 1;
    localparam int REQ_DMA = 2;
    localparam int REQ_DBG = 3;

    localparam int WORD_W   = 64;
    localparam int BANK_W   = 32;
    localparam int WORD_BE  = WORD_W / 8;
    localparam int BANK_BE  = BANK_W / 8;

    typedef enum logic [1:0] {
        PORT_ITCM  = 2'd0,
        PORT_DBANK0 = 2'd1,
        PORT_DBANK1 = 2'd2
    } port_e;

    // precedence list, highest first
    localparam int PRIO [NUM_REQ] = '{REQ_DBG, REQ_LS, REQ_DMA, REQ_PF};

    typedef struct packed {
        logic               we;
        logic [WORD_BE-1:0] be;
        logic [WORD_W-1:0]  wdata;
    } access_t;

    function automatic port_e port_of(input logic dsel, input logic bank);
        if (!dsel)
            return PORT_ITCM;
        return bank ? PORT_DBANK1 : PORT_DBANK0;
    endfunction

endpackage

// File: rtl/tcm_port_arb.sv
module tcm_port_arb
    import tcm_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] hit_i,
    output logic [NUM_REQ-1:0] gnt_o
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt_o = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (!taken && hit_i[PRIO[k]]) begin
                gnt_o[PRIO[k]] = 1'b1;
                taken = 1'b1;
            end
        end
    end

    assert_one_owner_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    assert_work_conserving_R6: assert property (@(posedge clk) disable iff (rst)
        (|hit_i) |-> (|gnt_o));

    assert_debug_first_R6: assert property (@(posedge clk) disable iff (rst)
        hit_i[REQ_DBG] |-> gnt_o[REQ_DBG]);

    assert_pf_last_R6: assert property (@(posedge clk) disable iff (rst)
        gnt_o[REQ_PF] |-> (hit_i == (NUM_REQ'(1) << REQ_PF)));

endmodule

// File: rtl/tcm_rd_return.sv
module tcm_rd_return
    import tcm_arb_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_PORT-1:0][NUM_REQ-1:0]     pgnt_i,
    input  logic [NUM_REQ-1:0]                   is_rd_i,
    input  logic [NUM_PORT-1:0][WORD_W-1:0]      prdata_i,
    output logic [NUM_REQ-1:0]                   rvalid_o,
    output logic [NUM_REQ-1:0][WORD_W-1:0]       rdata_o
);

    logic [NUM_PORT-1:0][NUM_REQ-1:0] owner_q;
    logic [NUM_REQ-1:0]               any_rd_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PORT; p++)
                owner_q[p] <= pgnt_i[p] & is_rd_i;
        end
    end

    always_comb begin
        rvalid_o   = '0;
        rdata_o    = '0;
        any_rd_gnt = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            for (int p = 0; p < NUM_PORT; p++) begin
                any_rd_gnt[r] = any_rd_gnt[r] | (pgnt_i[p][r] & is_rd_i[r]);
                if (owner_q[p][r]) begin
                    rvalid_o[r] = 1'b1;
                    rdata_o[r]  = rdata_o[r] | prdata_i[p];
                end
            end
        end
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_chk
        assert_rvalid_latency_R7: assert property (@(posedge clk) disable iff (rst)
            rvalid_o[r] |-> $past(any_rd_gnt[r]));
        assert_read_returns_R7: assert property (@(posedge clk) disable iff (rst)
            any_rd_gnt[r] |=> rvalid_o[r]);
    end

endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_REQ-1:0]            req_i,
    input  logic [NUM_REQ*ADDR_W-1:0]     addr_i,
    input  logic [NUM_REQ-1:0]            we_i,
    input  logic [NUM_REQ*WORD_BE-1:0]    be_i,
    input  logic [NUM_REQ*WORD_W-1:0]     wdata_i,
    output logic [NUM_REQ-1:0]            gnt_o,
    output logic [NUM_REQ-1:0]            rvalid_o,
    output logic [NUM_REQ*WORD_W-1:0]     rdata_o,
    output logic                          pf_err_o,
    output logic                          itcm_en_o,
    output logic                          itcm_we_o,
    output logic [ADDR_W-5:0]             itcm_idx_o,
    output logic [WORD_BE-1:0]            itcm_be_o,
    output logic [WORD_W-1:0]             itcm_wdata_o,
    input  logic [WORD_W-1:0]             itcm_rdata_i,
    output logic [1:0]                    dtcm_en_o,
    output logic [1:0]                    dtcm_we_o,
    output logic [2*(ADDR_W-4)-1:0]       dtcm_idx_o,
    output logic [2*BANK_BE-1:0]          dtcm_be_o,
    output logic [2*BANK_W-1:0]           dtcm_wdata_o,
    input  logic [2*BANK_W-1:0]           dtcm_rdata_i
);

    localparam int IDX_W = ADDR_W - 4;

    logic [ADDR_W-1:0]                 req_addr [NUM_REQ];
    access_t                           req_acc  [NUM_REQ];
    logic [NUM_REQ-1:0]                eligible;
    logic [NUM_PORT-1:0][NUM_REQ-1:0]  hit;
    logic [NUM_PORT-1:0][NUM_REQ-1:0]  pgnt;
    access_t                           port_acc [NUM_PORT];
    logic [IDX_W-1:0]                  port_idx [NUM_PORT];
    logic [NUM_PORT-1:0][WORD_W-1:0]   prdata;
    logic [NUM_REQ-1:0][WORD_W-1:0]    rdata_w;
    logic                              err_q;

    // unpack requesters, qualify and steer to a port
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        assign req_addr[r] = addr_i[r*ADDR_W +: ADDR_W];
        assign req_acc[r]  = '{we:    we_i[r],
                               be:    be_i[r*WORD_BE +: WORD_BE],
                               wdata: wdata_i[r*WORD_W +: WORD_W]};
        if (r == REQ_PF) begin : g_ro
            assign eligible[r] = req_i[r] & ~we_i[r] & ~rst;
        end else begin : g_rw
            assign eligible[r] = req_i[r] & ~rst;
        end
        for (genvar p = 0; p < NUM_PORT; p++) begin : g_hit
            assign hit[p][r] = eligible[r] &&
                (port_of(req_addr[r][ADDR_W-1], req_addr[r][2]) == port_e'(p));
        end
        assign rdata_o[r*WORD_W +: WORD_W] = rdata_w[r];
    end

    // one arbiter and one access mux per memory port
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        tcm_port_arb u_arb (
            .clk   (clk),
            .rst   (rst),
            .hit_i (hit[p]),
            .gnt_o (pgnt[p])
        );

        always_comb begin
            port_acc[p] = '0;
            port_idx[p] = '0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (pgnt[p][r]) begin
                    port_acc[p] = req_acc[r];
                    port_idx[p] = req_addr[r][ADDR_W-2:3];
                end
            end
        end
    end

    always_comb begin
        gnt_o = '0;
        for (int p = 0; p < NUM_PORT; p++)
            gnt_o = gnt_o | pgnt[p];
    end

    // instruction memory port
    assign itcm_en_o    = |pgnt[PORT_ITCM];
    assign itcm_we_o    = port_acc[PORT_ITCM].we;
    assign itcm_idx_o   = port_idx[PORT_ITCM];
    assign itcm_be_o    = port_acc[PORT_ITCM].be;
    assign itcm_wdata_o = port_acc[PORT_ITCM].wdata;
    assign prdata[PORT_ITCM] = itcm_rdata_i;

    // data memory banks
    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int P = int'(PORT_DBANK0) + b;
        assign dtcm_en_o[b]                      = |pgnt[P];
        assign dtcm_we_o[b]                      = port_acc[P].we;
        assign dtcm_idx_o[b*IDX_W +: IDX_W]      = port_idx[P];
        assign dtcm_be_o[b*BANK_BE +: BANK_BE]   = port_acc[P].be[BANK_BE-1:0];
        assign dtcm_wdata_o[b*BANK_W +: BANK_W]  = port_acc[P].wdata[BANK_W-1:0];
        assign prdata[P] = {{(WORD_W-BANK_W){1'b0}}, dtcm_rdata_i[b*BANK_W +: BANK_W]};
    end

    tcm_rd_return u_ret (
        .clk      (clk),
        .rst      (rst),
        .pgnt_i   (pgnt),
        .is_rd_i  (~we_i),
        .prdata_i (prdata),
        .rvalid_o (rvalid_o),
        .rdata_o  (rdata_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= req_i[REQ_PF] & we_i[REQ_PF];
    end
    assign pf_err_o = err_q;

    assert_pf_write_refused_R2: assert property (@(posedge clk) disable iff (rst)
        (req_i[REQ_PF] && we_i[REQ_PF]) |-> !gnt_o[REQ_PF]);

    assert_pf_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
        pf_err_o |-> $past(req_i[REQ_PF] && we_i[REQ_PF]));

    assert_pf_err_raised_R2: assert property (@(posedge clk) disable iff (rst)
        (req_i[REQ_PF] && we_i[REQ_PF]) |=> pf_err_o);

    assert_no_grant_in_reset_R1: assert property (@(posedge clk)
        rst |-> (gnt_o == '0));

    assert_dual_bank_R5: assert property (@(posedge clk) disable iff (rst)
        ((|hit[PORT_DBANK0]) && (|hit[PORT_DBANK1])) |-> (dtcm_en_o == 2'b11));

    assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt_o & ~req_i) == '0);

endmodule

// File: tb/tcm_arbiter_tb_top.sv
module tcm_arbiter_tb_top;
    import tcm_arb_pkg::*;

    localparam int AW    = 12;
    localparam int IW    = AW - 4;
    localparam int DEPTH = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]        rq, wq;
    logic [AW-1:0]     ad [4];
    logic [7:0]        bs [4];
    logic [63:0]       wd [4];

    logic [4*AW-1:0]   addr_f;
    logic [31:0]       be_f;
    logic [255:0]      wdata_f;
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            addr_f[r*AW +: AW] = ad[r];
            be_f[r*8 +: 8]     = bs[r];
            wdata_f[r*64 +: 64] = wd[r];
        end
    end

    logic [3:0]   gnt, rvalid;
    logic [255:0] rdata;
    logic         pf_err;
    logic         i_en, i_we;
    logic [IW-1:0] i_idx;
    logic [7:0]   i_be;
    logic [63:0]  i_wd, i_rd;
    logic [1:0]   d_en, d_we;
    logic [2*IW-1:0] d_idx;
    logic [7:0]   d_be;
    logic [63:0]  d_wd, d_rd;

    tcm_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_i(rq), .addr_i(addr_f), .we_i(wq),
        .be_i(be_f), .wdata_i(wdata_f), .gnt_o(gnt), .rvalid_o(rvalid),
        .rdata_o(rdata), .pf_err_o(pf_err),
        .itcm_en_o(i_en), .itcm_we_o(i_we), .itcm_idx_o(i_idx),
        .itcm_be_o(i_be), .itcm_wdata_o(i_wd), .itcm_rdata_i(i_rd),
        .dtcm_en_o(d_en), .dtcm_we_o(d_we), .dtcm_idx_o(d_idx),
        .dtcm_be_o(d_be), .dtcm_wdata_o(d_wd), .dtcm_rdata_i(d_rd)
    );

    // synchronous RAM models
    logic [63:0] mem_i [DEPTH];
    logic [31:0] mem_d [2][DEPTH];
    logic [63:0] sh_i  [DEPTH];
    logic [31:0] sh_d  [2][DEPTH];

    always @(posedge clk) begin
        if (i_en) begin
            if (i_we) begin
                for (int b = 0; b < 8; b++)
                    if (i_be[b]) mem_i[i_idx][8*b +: 8] <= i_wd[8*b +: 8];
            end else begin
                i_rd <= mem_i[i_idx];
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (d_en[k]) begin
                if (d_we[k]) begin
                    for (int b = 0; b < 4; b++)
                        if (d_be[4*k+b]) mem_d[k][d_idx[k*IW +: IW]][8*b +: 8] <= d_wd[32*k+8*b +: 8];
                end else begin
                    d_rd[32*k +: 32] <= mem_d[k][d_idx[k*IW +: IW]];
                end
            end
        end
    end

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int tgt_of(input logic [AW-1:0] a);
        if (!a[AW-1]) return 0;
        return a[2] ? 2 : 1;
    endfunction

    function automatic logic [AW-1:0] mk_addr(input int t, input int idx);
        logic [AW-1:0] a;
        a = '0;
        a[AW-1]  = (t != 0);
        a[AW-2:3] = IW'(idx);
        a[2]     = (t == 2);
        return a;
    endfunction

    function automatic int rank(input int r);
        case (r)
            3: return 0;
            0: return 1;
            2: return 2;
            default: return 3;
        endcase
    endfunction

    // apply the current inputs for one clock and check everything it implies
    task automatic step(input string tag);
        bit          ok  [4];
        bit          eg  [4];
        bit          erv [4];
        logic [63:0] erd [4];
        bit          eerr;
        #5;
        for (int r = 0; r < 4; r++)
            ok[r] = rq[r] && !(r == 1 && wq[r]);
        for (int r = 0; r < 4; r++) begin
            eg[r] = ok[r];
            for (int o = 0; o < 4; o++)
                if (o != r && ok[o] && tgt_of(ad[o]) == tgt_of(ad[r]) && rank(o) < rank(r))
                    eg[r] = 1'b0;
            chk($sformatf("R5 R6 grant req%0d %s", r, tag), 64'(gnt[r]), 64'(eg[r]));
        end
        eerr = rq[1] && wq[1];
        for (int r = 0; r < 4; r++) begin
            int t, ix;
            t  = tgt_of(ad[r]);
            ix = int'(ad[r][AW-2:3]);
            erv[r] = eg[r] && !wq[r];
            erd[r] = (t == 0) ? sh_i[ix] : {32'h0, sh_d[t-1][ix]};
        end
        for (int r = 0; r < 4; r++) begin
            if (eg[r] && wq[r]) begin
                int t, ix;
                t  = tgt_of(ad[r]);
                ix = int'(ad[r][AW-2:3]);
                if (t == 0) begin
                    for (int b = 0; b < 8; b++)
                        if (bs[r][b]) sh_i[ix][8*b +: 8] = wd[r][8*b +: 8];
                end else begin
                    for (int b = 0; b < 4; b++)
                        if (bs[r][b]) sh_d[t-1][ix][8*b +: 8] = wd[r][8*b +: 8];
                end
            end
        end
        @(posedge clk);
        #5;
        for (int r = 0; r < 4; r++) begin
            chk($sformatf("R7 rvalid req%0d %s", r, tag), 64'(rvalid[r]), 64'(erv[r]));
            if (erv[r])
                chk($sformatf("R3 R4 R7 rdata req%0d %s", r, tag), rdata[r*64 +: 64], erd[r]);
        end
        chk($sformatf("R2 pf_err %s", tag), 64'(pf_err), 64'(eerr));
        @(negedge clk);
    endtask

    task automatic idle();
        rq = '0;
        wq = '0;
        for (int r = 0; r < 4; r++) begin
            ad[r] = '0;
            bs[r] = '0;
            wd[r] = '0;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [63:0] v;
            v = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
            mem_i[i] = v;       sh_i[i] = v;
            mem_d[0][i] = v[31:0];  sh_d[0][i] = v[31:0];
            mem_d[1][i] = v[63:32]; sh_d[1][i] = v[63:32];
        end
        i_rd = '0;
        d_rd = '0;
        idle();

        // R1: grants held low in reset even with every requester active
        @(negedge clk);
        rq = 4'hF;
        #5;
        chk("R1 grants during reset", 64'(gnt), 64'h0);
        @(negedge clk);
        idle();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk("R1 rvalid after reset", 64'(rvalid), 64'h0);
        chk("R1 pf_err after reset", 64'(pf_err), 64'h0);
        @(negedge clk);

        // R5 R6 R3 R4 R7: every requester mask across every target mix,
        // first reads only, then mixed reads and writes (including refused prefetch writes)
        for (int pass = 0; pass < 2; pass++) begin
            for (int m = 0; m < 16; m++) begin
                for (int c = 0; c < 81; c++) begin
                    int div;
                    div = 1;
                    for (int r = 0; r < 4; r++) begin
                        int t;
                        t     = (c / div) % 3;
                        div   = div * 3;
                        ad[r] = mk_addr(t, (c*7 + r*61 + m*13 + pass*101) % DEPTH);
                        wq[r] = (pass == 1) && (((c + r*3 + m) % 3) == 0);
                        bs[r] = 8'(c*29 + r*71 + m);
                        wd[r] = {32'(c*r + 32'h5A00 + m), 32'(~(c*13 + r + m*977))};
                    end
                    rq = 4'(m);
                    step($sformatf("sweep p%0d m%0d c%0d", pass, m, c));
                end
            end
        end

        // R8 R9: each writer, each memory, every low strobe pattern, then read back
        for (int ri = 0; ri < 3; ri++) begin
            int r;
            r = (ri == 0) ? 0 : (ri == 1) ? 2 : 3;
            for (int t = 0; t < 3; t++) begin
                for (int s = 0; s < 16; s++) begin
                    idle();
                    rq[r] = 1'b1;
                    wq[r] = 1'b1;
                    ad[r] = mk_addr(t, 17 + s);
                    bs[r] = (t == 0) ? {4'(s ^ 4'h9), 4'(s)} : {4'h0, 4'(s)};
                    wd[r] = {32'hC0DE_0000 + 32'(s), 32'hF00D_0000 + 32'(r*16 + t)};
                    step($sformatf("R8 R9 write req%0d tgt%0d be%0d", r, t, s));
                    wq[r] = 1'b0;
                    step($sformatf("R8 R9 readback req%0d tgt%0d be%0d", r, t, s));
                end
            end
        end

        // R2: refused prefetch write leaves memory alone; a DMA read shows the old word
        for (int t = 0; t < 3; t++) begin
            idle();
            rq[1] = 1'b1;
            wq[1] = 1'b1;
            ad[1] = mk_addr(t, 200);
            bs[1] = 8'hFF;
            wd[1] = 64'hDEAD_BEEF_DEAD_BEEF;
            step($sformatf("R2 pf write tgt%0d", t));
            idle();
            rq[2] = 1'b1;
            ad[2] = mk_addr(t, 200);
            step($sformatf("R2 unchanged tgt%0d", t));
        end

        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule